// File: doc/BRIEF.md
# Level-Combined Key Press Interrupt

This block watches a bank of key inputs, ten by default, and merges them into one interrupt line. One polarity input chooses what counts as a press. At 0 a key is pressed while its input is low, so a falling edge starts a press. At 1 a key is pressed while its input is high, so a rising edge starts a press. Each raw input is resynchronised to the block clock. The inputs are then filtered by a per-key enable mask and combined by OR.

The combined line follows the input levels and does not store edges. It stays high as long as any enabled key is pressed, and a second key pressed during that time does not produce a second event. A sticky request flag is set each time the combined line goes from low to high. It is cleared by an interrupt acknowledge strobe or by a software clear strobe.

The block keeps no record of which key caused the event. Software finds the source by reading the key levels after the interrupt.

Top module: `keypress_irq_combiner`

## Requirements
- R1: With `edge_rising` = 0, a key is active while its input is 0. `key_irq` is 1 while at least one enabled key is at 0.
- R2: With `edge_rising` = 1, a key is active while its input is 1. The same combining rule as R1 applies.
- R3: `key_irq` returns to 0 only when every enabled key is back at its inactive level.
- R4: While `key_irq` is already 1, a key entering its active level does not set `irq_req` again.
- R5: `irq_req` goes to 1 on the clock edge after `key_irq` changes from 0 to 1. It then holds until it is cleared.
- R6: A one-cycle pulse on `irq_ack` or on `sw_clear` clears `irq_req`.
- R7: A key whose bit in `key_en` is 0 has no effect on `key_irq`. A change of `key_en` that raises `key_irq` counts as a new event and sets `irq_req`.
- R8: A change on a key input reaches `key_irq` after exactly two rising clock edges. `irq_req` follows on the third edge.
- R9: If a set event and a clear strobe fall in the same cycle, `irq_req` ends up at 1.
- R10: While `rst_n` is 0, `key_irq` and `irq_req` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_in | input | NUM_KEYS | Raw key inputs, asynchronous to `clk` |
| key_en | input | NUM_KEYS | Per-key enable; a bit at 1 includes that key in the combination |
| edge_rising | input | 1 | Press polarity: 0 selects active-low keys, 1 selects active-high keys |
| irq_ack | input | 1 | Interrupt acknowledge strobe; clears the request flag |
| sw_clear | input | 1 | Software clear strobe; clears the request flag |
| key_irq | output | 1 | Combined level of all enabled, pressed keys |
| irq_req | output | 1 | Sticky interrupt request flag |

## Verification
The hardest case to reach is a set event and a clear strobe on the same clock edge. The set event is the rise of `key_irq` that occurs two edges after a key changes. The bench drops a key, counts two edges, and raises `sw_clear` so that it lands on the edge where the flag is set. The masking case is reached by pressing a second key while the first one is held, then releasing the keys one at a time and checking that the flag stays clear.

// File: rtl/kirq_pkg.sv
package kirq_pkg;

   typedef enum logic {
      POL_FALL = 1'b0,
      POL_RISE = 1'b1
   } edge_pol_e;

   localparam int DEFAULT_KEYS   = 10;
   localparam int MIN_SYNC_DEPTH = 2;

endpackage

// File: rtl/kirq_polarity.sv
module kirq_polarity
   import kirq_pkg::*;
#(
   parameter int NUM_KEYS = DEFAULT_KEYS
) (
   input  logic [NUM_KEYS-1:0] raw,
   input  edge_pol_e           pol,
   output logic [NUM_KEYS-1:0] active
);

   // Map every key to an active-high view so that reset value 0 means idle.
   always_comb begin
      if (pol == POL_RISE) active = raw;
      else                 active = ~raw;
   end

endmodule

// File: rtl/kirq_sync.sv
module kirq_sync
   import kirq_pkg::*;
#(
   parameter int NUM_KEYS = DEFAULT_KEYS,
   parameter int STAGES   = MIN_SYNC_DEPTH
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_KEYS-1:0] d,
   output logic [NUM_KEYS-1:0] q
);

   logic [NUM_KEYS-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/kirq_merge.sv
module kirq_merge
   import kirq_pkg::*;
#(
   parameter int NUM_KEYS = DEFAULT_KEYS
) (
   input  logic [NUM_KEYS-1:0] active,
   input  logic [NUM_KEYS-1:0] enable,
   output logic                any_on
);

   assign any_on = |(active & enable);

endmodule

// File: rtl/kirq_flag.sv
module kirq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic clr,
   output logic flag
);

   logic level_q;
   logic set_evt;

   assign set_evt = level & ~level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         flag    <= 1'b0;
      end else begin
         level_q <= level;
         if (set_evt)  flag <= 1'b1;
         else if (clr) flag <= 1'b0;
      end
   end

endmodule

// File: rtl/keypress_irq_combiner.sv
module keypress_irq_combiner
   import kirq_pkg::*;
#(
   parameter int NUM_KEYS   = DEFAULT_KEYS,
   parameter int SYNC_DEPTH = MIN_SYNC_DEPTH
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_KEYS-1:0] key_in,
   input  logic [NUM_KEYS-1:0] key_en,
   input  logic                edge_rising,
   input  logic                irq_ack,
   input  logic                sw_clear,
   output logic                key_irq,
   output logic                irq_req
);

   localparam int KEY_W = NUM_KEYS;

   if (NUM_KEYS < 1) begin : g_bad_keys
      $error("keypress_irq_combiner: NUM_KEYS must be at least 1");
   end
   if (SYNC_DEPTH < MIN_SYNC_DEPTH) begin : g_bad_depth
      $error("keypress_irq_combiner: SYNC_DEPTH below minimum");
   end

   edge_pol_e          pol;
   logic [KEY_W-1:0]   act_raw;
   logic [KEY_W-1:0]   act_sync;

   assign pol = edge_pol_e'(edge_rising);

   kirq_polarity #(.NUM_KEYS(KEY_W)) i_pol (
      .raw    (key_in),
      .pol    (pol),
      .active (act_raw)
   );

   kirq_sync #(.NUM_KEYS(KEY_W), .STAGES(SYNC_DEPTH)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (act_raw),
      .q     (act_sync)
   );

   kirq_merge #(.NUM_KEYS(KEY_W)) i_merge (
      .active (act_sync),
      .enable (key_en),
      .any_on (key_irq)
   );

   kirq_flag i_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .level (key_irq),
      .clr   (irq_ack | sw_clear),
      .flag  (irq_req)
   );

endmodule

// File: rtl/kirq_checker.sv
module kirq_checker #(
   parameter int NUM_KEYS = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_KEYS-1:0] key_en,
   input logic                irq_ack,
   input logic                sw_clear,
   input logic                key_irq,
   input logic                irq_req
);

   AST_REQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_irq) |=> irq_req); // R5

   AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack && !sw_clear) |=> irq_req); // R5

   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_ack || sw_clear) && !$rose(key_irq)) |=> !irq_req); // R6

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(key_irq) && (irq_ack || sw_clear)) |=> irq_req); // R9

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_req && !$rose(key_irq)) |=> !irq_req); // R4

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (key_en == '0) |-> !key_irq); // R7

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> (!irq_req && !key_irq)); // R10

endmodule

bind keypress_irq_combiner kirq_checker #(.NUM_KEYS(NUM_KEYS)) i_kirq_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .key_en   (key_en),
   .irq_ack  (irq_ack),
   .sw_clear (sw_clear),
   .key_irq  (key_irq),
   .irq_req  (irq_req)
);

// File: tb/test_keypress_irq_combiner.sv
module test_keypress_irq_combiner;

   localparam int  N       = 10;
   localparam time CLK_PER = 10ns;
   localparam int  NVEC    = 12;
   localparam int  WDOG    = 200000;

   // vector: key_in, key_en, edge_rising, exp key_irq, exp irq_req
   localparam logic [22:0] VEC [NVEC] = '{
      {10'h3FF, 10'h3FF, 1'b0, 1'b0, 1'b0},  // R1 idle high
      {10'h3FE, 10'h3FF, 1'b0, 1'b1, 1'b1},  // R1 key0 pressed
      {10'h3FC, 10'h3FF, 1'b0, 1'b1, 1'b0},  // R4 key1 during key0
      {10'h3FD, 10'h3FF, 1'b0, 1'b1, 1'b0},  // R3 key1 still held
      {10'h3FF, 10'h3FF, 1'b0, 1'b0, 1'b0},  // R3 all released
      {10'h1FF, 10'h1FF, 1'b0, 1'b0, 1'b0},  // R7 key9 disabled
      {10'h1FF, 10'h3FF, 1'b0, 1'b1, 1'b1},  // R7 enable raises
      {10'h3FF, 10'h3FF, 1'b0, 1'b0, 1'b0},  // R3 release
      {10'h000, 10'h3FF, 1'b1, 1'b0, 1'b0},  // R2 idle low
      {10'h020, 10'h3FF, 1'b1, 1'b1, 1'b1},  // R2 key5 high
      {10'h000, 10'h3FF, 1'b1, 1'b0, 1'b0},  // R2 release
      {10'h201, 10'h200, 1'b1, 1'b1, 1'b1}   // R7 key0 masked, key9 on
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] key_in = '1;
   logic [N-1:0] key_en = '1;
   logic         edge_rising = 1'b0;
   logic         irq_ack = 1'b0;
   logic         sw_clear = 1'b0;
   logic         key_irq;
   logic         irq_req;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   keypress_irq_combiner #(.NUM_KEYS(N)) i_keypress_irq_combiner (
      .clk (clk), .rst_n (rst_n), .key_in (key_in), .key_en (key_en),
      .edge_rising (edge_rising), .irq_ack (irq_ack), .sw_clear (sw_clear),
      .key_irq (key_irq), .irq_req (irq_req)
   );

   task automatic check(input string req, input logic got, input logic exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      cycles(WDOG);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R10 reset state
      cycles(3);
      check("R10 key_irq in reset", key_irq, 1'b0);
      check("R10 irq_req in reset", irq_req, 1'b0);
      rst_n = 1'b1;
      cycles(3);

      // table walk; R6 software clear before each step
      for (int v = 0; v < NVEC; v++) begin
         sw_clear = 1'b1;
         cycles(1);
         sw_clear = 1'b0;
         check("R6 sw_clear", irq_req, 1'b0);
         {key_in, key_en, edge_rising} = VEC[v][22:2];
         cycles(4);
         check($sformatf("R1/R2/R3 key_irq vec %0d", v), key_irq, VEC[v][1]);
         check($sformatf("R4/R5/R7 irq_req vec %0d", v), irq_req, VEC[v][0]);
      end

      // back to falling mode, idle
      key_in = '1; key_en = '1; edge_rising = 1'b0;
      cycles(4);
      sw_clear = 1'b1; cycles(1); sw_clear = 1'b0;

      // R8 latency: key3 drops at a negedge
      key_in = 10'h3F7;
      cycles(1);
      check("R8 key_irq after 1 edge", key_irq, 1'b0);
      cycles(1);
      check("R8 key_irq after 2 edges", key_irq, 1'b1);
      check("R8 irq_req after 2 edges", irq_req, 1'b0);
      cycles(1);
      check("R8 irq_req after 3 edges", irq_req, 1'b1);

      // R6 acknowledge clears
      irq_ack = 1'b1; cycles(1); irq_ack = 1'b0;
      check("R6 irq_ack clears", irq_req, 1'b0);
      key_in = '1;
      cycles(4);

      // R9 set and clear on the same edge
      key_in = 10'h3EF;
      cycles(2);
      sw_clear = 1'b1;
      cycles(1);
      sw_clear = 1'b0;
      check("R9 set wins over clear", irq_req, 1'b1);

      // R10 reset mid-run
      rst_n = 1'b0;
      cycles(1);
      check("R10 irq_req after reset", irq_req, 1'b0);
      check("R10 key_irq after reset", key_irq, 1'b0);
      finish_run();
   end

endmodule